// File: doc/BRIEF.md
# PHY Test-Port Register Write Master

This block carries out single register writes into a PHY that exposes a test port. The port is driven through one parallel control word. That word holds a data byte, a register address, a port select, a write-enable flag, a test clock and an active-low test reset. The PHY captures a write on the rising edge of the test clock. The block makes that edge by presenting the same word three times in a row: test clock low, then high, then low again.

A requester presents a port number, an address and a data byte with `req_valid`. The write is accepted on the first clock edge where `req_ready` is also high. `req_ready` then stays low until the last phase is over. In the cycle it returns high, `wr_done` pulses for one cycle. Each phase lasts `PHASE_CYC` system clocks, with a minimum of one.

The static input `layout_sel` chooses one of two packings of the control word. Layout 0 is the wide packing. Layout 1 is a narrower 16-bit packing, and in it the bits above 15 are always zero. When the block is idle, the word carries only the inactive test reset.

Top module: `tport_wr_master`

## Requirements
- R1: In both layouts the data byte appears on `ctrl_word[7:0]` while a write is in progress.
- R2: With `layout_sel`=0 the word carries the address on [15:8], the port on [18:16], write enable on bit 21, the test clock on bit 22 and the active-low test reset on bit 23. All other bits are 0.
- R3: With `layout_sel`=1 the word carries the address on [11:8], the port on bit 12, write enable on bit 13, the test clock on bit 14 and the active-low test reset on bit 15. Bits [23:16] are 0 at all times.
- R4: Address and port bits that do not fit their field are dropped. In layout 1, address 0xAB is sent as 0xB and port 3 is sent as 1.
- R5: For the whole of a write, write enable is 1 and the test reset bit is 1 (inactive).
- R6: A write presents the same word in three phases of `PHASE_CYC` cycles each. The test clock is low in the first phase, high in the second and low in the third. The first phase starts in the cycle after acceptance.
- R7: `req_ready` is low from the cycle after acceptance until the third phase ends. A request held on `req_valid` during that time starts no further write and does not change the word.
- R8: `wr_done` is high for exactly one cycle, in the cycle after the third phase. In that same cycle `req_ready` is 1 again.
- R9: While idle, the word has only the test reset bit of the selected layout set: 0x800000 in layout 0 and 0x008000 in layout 1.
- R10: After reset, `req_ready` is 1, `wr_done` is 0 and the word is the idle word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block can accept a request |
| req_port | input | 3 | Target port number |
| req_addr | input | 8 | Target register address |
| req_data | input | 8 | Data byte to write |
| layout_sel | input | 1 | Control word layout: 0 wide, 1 narrow |
| ctrl_word | output | 24 | Control word to the PHY test port |
| wr_done | output | 1 | One-cycle pulse when a write completes |

## Verification
The assertions assume that `layout_sel` is constant from reset onward and only ever changes while the block is idle. The bit positions that the checker decodes depend on it. The stimulus changes the layout only between writes, after `wr_done` has gone low. It changes requests only on the falling clock edge. Request fields are allowed to change while a write is in progress, because the block holds its own copy of the request. One scenario deliberately keeps `req_valid` high with different fields during a write to check that the word does not change.

// File: rtl/tport_pkg.sv
package tport_pkg;

    localparam int unsigned WORD_W  = 24;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned ADDR_W  = 8;
    localparam int unsigned PORT_W  = 3;
    localparam int unsigned NUM_LAY = 2;

    typedef struct packed {
        logic [PORT_W-1:0] port;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_LEAD   = 2'd1,
        PH_STROBE = 2'd2,
        PH_TRAIL  = 2'd3
    } phase_e;

    typedef struct packed {
        logic we;
        logic tck;
    } strobe_t;

    // Field placement of one control word layout
    typedef struct packed {
        logic [4:0]        addr_sh;
        logic [WORD_W-1:0] addr_msk;
        logic [4:0]        port_sh;
        logic [WORD_W-1:0] port_msk;
        logic [4:0]        we_bit;
        logic [4:0]        tck_bit;
        logic [4:0]        rstn_bit;
    } lay_desc_t;

    localparam logic [WORD_W-1:0] DATA_MSK = 24'h0000FF;

    function automatic lay_desc_t lay_desc(input logic lay);
        lay_desc_t d;
        if (lay == 1'b0) begin
            d.addr_sh  = 5'd8;
            d.addr_msk = 24'h00FF00;
            d.port_sh  = 5'd16;
            d.port_msk = 24'h070000;
            d.we_bit   = 5'd21;
            d.tck_bit  = 5'd22;
            d.rstn_bit = 5'd23;
        end else begin
            d.addr_sh  = 5'd8;
            d.addr_msk = 24'h000F00;
            d.port_sh  = 5'd12;
            d.port_msk = 24'h001000;
            d.we_bit   = 5'd13;
            d.tck_bit  = 5'd14;
            d.rstn_bit = 5'd15;
        end
        return d;
    endfunction

    function automatic logic [WORD_W-1:0] bit_at(input logic v, input logic [4:0] pos);
        return {{(WORD_W-1){1'b0}}, v} << pos;
    endfunction

endpackage

// File: rtl/tport_phase_timer.sv
module tport_phase_timer #(
    parameter int unsigned PHASE_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic expire
);
    localparam int unsigned CNT_W = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PHASE_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    assign expire = active && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!active || expire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tport_seq.sv
module tport_seq
    import tport_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    req_valid,
    input  wr_req_t req_in,
    input  logic    expire,
    output logic    busy,
    output wr_req_t req_q,
    output strobe_t strobe,
    output logic    done
);
    phase_e state_q;

    assign busy       = (state_q != PH_IDLE);
    assign strobe.we  = busy;
    assign strobe.tck = (state_q == PH_STROBE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_IDLE;
            req_q   <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                PH_IDLE: begin
                    if (req_valid) begin
                        req_q   <= req_in;
                        state_q <= PH_LEAD;
                    end
                end
                PH_LEAD: begin
                    if (expire) state_q <= PH_STROBE;
                end
                PH_STROBE: begin
                    if (expire) state_q <= PH_TRAIL;
                end
                PH_TRAIL: begin
                    if (expire) begin
                        state_q <= PH_IDLE;
                        done    <= 1'b1;
                    end
                end
                default: state_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tport_word_pack.sv
module tport_word_pack
    import tport_pkg::*;
#(
    parameter int unsigned LAYOUT = 0
) (
    input  wr_req_t           req,
    input  strobe_t           strobe,
    output logic [WORD_W-1:0] word
);
    localparam lay_desc_t D = lay_desc(LAYOUT[0]);

    logic [WORD_W-1:0] data_f, addr_f, port_f, ctl_f;

    always_comb begin
        data_f = WORD_W'(req.data) & DATA_MSK;
        addr_f = (WORD_W'(req.addr) << D.addr_sh) & D.addr_msk;
        port_f = (WORD_W'(req.port) << D.port_sh) & D.port_msk;
        ctl_f  = bit_at(strobe.we, D.we_bit)
               | bit_at(strobe.tck, D.tck_bit)
               | bit_at(1'b1, D.rstn_bit);
        word   = data_f | addr_f | port_f | ctl_f;
    end
endmodule

// File: rtl/tport_wr_master.sv
module tport_wr_master
    import tport_pkg::*;
#(
    parameter int unsigned PHASE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [PORT_W-1:0] req_port,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              layout_sel,
    output logic [WORD_W-1:0] ctrl_word,
    output logic              wr_done
);
    wr_req_t req_in, req_q, req_out;
    strobe_t strobe;
    logic    busy, expire;
    logic [WORD_W-1:0] word_v [NUM_LAY];

    assign req_in = '{port: req_port, addr: req_addr, data: req_data};

    tport_phase_timer #(.PHASE_CYC(PHASE_CYC)) timer_i (
        .clk    (clk),
        .rst    (rst),
        .active (busy),
        .expire (expire)
    );

    tport_seq seq_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_in    (req_in),
        .expire    (expire),
        .busy      (busy),
        .req_q     (req_q),
        .strobe    (strobe),
        .done      (wr_done)
    );

    // Idle word carries no request fields
    assign req_out = busy ? req_q : '0;

    for (genvar g = 0; g < NUM_LAY; g++) begin : g_lay
        tport_word_pack #(.LAYOUT(g)) pack_i (
            .req    (req_out),
            .strobe (strobe),
            .word   (word_v[g])
        );
    end

    assign ctrl_word = word_v[layout_sel];
    assign req_ready = !busy;
endmodule

// File: rtl/tport_wr_master_chk.sv
module tport_wr_master_chk
    import tport_pkg::*;
#(
    parameter int unsigned PHASE_CYC = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              layout_sel,
    input logic [WORD_W-1:0] ctrl_word,
    input logic              wr_done
);
    lay_desc_t d;
    logic tck, we, rstn;
    int unsigned hi_cnt;

    always_comb begin
        d    = lay_desc(layout_sel);
        tck  = ctrl_word[d.tck_bit];
        we   = ctrl_word[d.we_bit];
        rstn = ctrl_word[d.rstn_bit];
    end

    always_ff @(posedge clk) begin
        if (rst || !tck) hi_cnt <= 0;
        else             hi_cnt <= hi_cnt + 1;
    end

    // R7
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);
    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        wr_done |=> !wr_done);
    // R8
    done_ready_chk: assert property (@(posedge clk) disable iff (rst)
        wr_done |-> req_ready);
    // R5
    busy_ctl_chk: assert property (@(posedge clk) disable iff (rst)
        !req_ready |-> (we && rstn));
    // R9
    idle_word_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!we && !tck && rstn));
    // R3
    narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
        layout_sel |-> (ctrl_word[23:16] == 8'h00));
    // R6
    strobe_stable_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tck) |-> ((ctrl_word & ~(24'h1 << d.tck_bit)) == ($past(ctrl_word) & ~(24'h1 << d.tck_bit))));
    // R6
    strobe_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(tck) |-> (hi_cnt == PHASE_CYC));
endmodule

bind tport_wr_master tport_wr_master_chk #(.PHASE_CYC(PHASE_CYC)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .layout_sel (layout_sel),
    .ctrl_word  (ctrl_word),
    .wr_done    (wr_done)
);

// File: tb/tport_wr_master_tb_top.sv
module tport_wr_master_tb_top;
    localparam int N = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_port = '0;
    logic [7:0]  req_addr = '0;
    logic [7:0]  req_data = '0;
    logic        layout_sel = 1'b0;
    logic [23:0] ctrl_word;
    logic        wr_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    tport_wr_master #(.PHASE_CYC(N)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_port(req_port), .req_addr(req_addr), .req_data(req_data),
        .layout_sel(layout_sel), .ctrl_word(ctrl_word), .wr_done(wr_done)
    );

    // Register-file model of the PHY side: captures on rising test clock
    int          cap_cnt = 0;
    logic [2:0]  cap_port;
    logic [7:0]  cap_addr, cap_data;
    logic        tck_prev = 1'b0;
    logic [7:0]  regfile [8][256];

    always @(negedge clk) begin
        logic tck_now;
        tck_now = layout_sel ? ctrl_word[14] : ctrl_word[22];
        if (!rst && tck_now && !tck_prev) begin
            cap_cnt++;
            cap_data = ctrl_word[7:0];
            if (layout_sel) begin
                cap_addr = {4'h0, ctrl_word[11:8]};
                cap_port = {2'b00, ctrl_word[12]};
            end else begin
                cap_addr = ctrl_word[15:8];
                cap_port = ctrl_word[18:16];
            end
            regfile[cap_port][cap_addr] = cap_data;
        end
        tck_prev = tck_now;
    end

    function automatic logic [23:0] exp_word(input logic lay, input logic [2:0] p,
        input logic [7:0] a, input logic [7:0] dt, input logic we, input logic tck);
        logic [23:0] w;
        if (!lay) w = {1'b1, tck, we, 2'b00, p, a, dt};
        else      w = {8'h00, 1'b1, tck, we, p[0], a[3:0], dt};
        return w;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready after reset", 24'(req_ready), 24'h1);
        chk(wr_done == 1'b0, "R10 done after reset", 24'(wr_done), 24'h0);
        chk(ctrl_word == 24'h800000, "R10 R9 idle word layout0", ctrl_word, 24'h800000);
    endtask

    task automatic t_set_layout(input logic lay);
        @(negedge clk);
        layout_sel = lay;
        #1;
        chk(ctrl_word == (lay ? 24'h008000 : 24'h800000), "R9 idle word after layout change",
            ctrl_word, lay ? 24'h008000 : 24'h800000);
    endtask

    task automatic t_write(input logic [2:0] p, input logic [7:0] a, input logic [7:0] dt,
                           input bit hold, input string tag);
        logic [7:0] ea;
        logic [2:0] ep;
        int cnt0;
        bit seq_ok = 1;
        ea = layout_sel ? {4'h0, a[3:0]} : a;
        ep = layout_sel ? {2'b00, p[0]} : p;
        cnt0 = cap_cnt;
        @(negedge clk);
        req_port = p; req_addr = a; req_data = dt; req_valid = 1'b1;
        @(posedge clk);
        for (int k = 0; k < 3*N; k++) begin
            logic [23:0] e;
            @(negedge clk);
            if (k == 0) begin
                if (hold) begin
                    req_port = ~p; req_addr = ~a; req_data = ~dt;
                end else begin
                    req_valid = 1'b0;
                end
            end
            e = exp_word(layout_sel, p, a, dt, 1'b1, (k / N) == 1);
            if (ctrl_word !== e) seq_ok = 0;
            chk(ctrl_word === e, {tag, " R1 R2 R3 R4 R5 R6 phase word"}, ctrl_word, e);
            chk(req_ready == 1'b0 && wr_done == 1'b0, {tag, " R7 ready low during write"},
                24'({req_ready, wr_done}), 24'h0);
        end
        @(negedge clk);
        chk(wr_done == 1'b1 && req_ready == 1'b1, {tag, " R8 done pulse with ready"},
            24'({req_ready, wr_done}), 24'h3);
        chk(ctrl_word == exp_word(layout_sel, 3'd0, 8'd0, 8'd0, 1'b0, 1'b0), {tag, " R9 idle after write"},
            ctrl_word, exp_word(layout_sel, 3'd0, 8'd0, 8'd0, 1'b0, 1'b0));
        req_valid = 1'b0;
        @(negedge clk);
        chk(wr_done == 1'b0, {tag, " R8 done one cycle"}, 24'(wr_done), 24'h0);
        chk(req_ready == 1'b1, {tag, " R7 no second write from held request"}, 24'(req_ready), 24'h1);
        chk(cap_cnt == cnt0 + 1, {tag, " R6 one capture edge"}, 24'(cap_cnt), 24'(cnt0 + 1));
        chk(regfile[ep][ea] == dt && cap_port == ep && cap_addr == ea, {tag, " R4 captured fields"},
            {cap_port, 5'd0, cap_addr, cap_data}, {ep, 5'd0, ea, dt});
        if (!seq_ok) $display("  sequence mismatch in %s", tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_write(3'd5, 8'h3C, 8'hA5, 1'b0, "L0 basic");
        t_write(3'd7, 8'hFF, 8'hFF, 1'b0, "L0 all ones");
        t_write(3'd0, 8'h00, 8'h00, 1'b1, "L0 held request");
        t_set_layout(1'b1);
        t_write(3'd1, 8'h06, 8'h04, 1'b0, "L1 basic");
        t_write(3'd3, 8'hAB, 8'h5A, 1'b0, "L1 masked R4");
        t_write(3'd6, 8'hF0, 8'hC3, 1'b1, "L1 held request");
        t_set_layout(1'b0);
        t_write(3'd2, 8'h81, 8'h7E, 1'b0, "L0 after switch");
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule